// File: doc/BRIEF.md
# Cache-to-Bus Single Access Bridge

This unit lets a data cache carry out one memory read or write of a single data word on an external bus. The cache loads a 30-bit word address register and, for a write, a 32-bit data register. A dedicated read-operation line chooses between the two kinds of access. Once the trigger condition is met, the unit raises a bus-master request and holds the processor stalled until the bus reports completion or a master abort. It then pulses a ready line for one cycle. On a read, the cache takes the result from the data register readback after ready. On a write, ready alone closes the access.

The controller has four states. `ST_IDLE` means nothing is in flight. `ST_ADDR_LOADED` means the address has been written by the cache. `ST_BUSY` means the bus request is outstanding. `ST_DONE` is the one-cycle ready slot. The transitions are these:
- `IDLE->ADDR_LOADED` on a cache address write.
- `ADDR_LOADED->BUSY` (launch) when the read line is high, or when the data register is loaded.
- `ADDR_LOADED->ADDR_LOADED` while it waits for data.
- `BUSY->DONE` (finish) on bus done or abort.
- `DONE->IDLE` unconditionally.

A software register port can read both registers. A software write to the data register is dropped. A software write to the address register updates the address but launches nothing. The bus side offers no path into either register.

Top module: `cache_bus_bridge`

## Requirements
- R1: After reset the state is IDLE: `c_stall`, `c_ready` and `m_req` are 0, and both registers read 0 on `sw_rdata`. A `sw_rsel` of 0 selects the address and 1 selects the data.
- R2: A cache address write with `c_rd_op` high, with `c_rd_op` kept high, raises `m_req` with `m_we`=0 and `m_addr` equal to the written address. This happens two clock edges after the write cycle.
- R3: A write access starts only when both the address and the data registers are loaded by the cache and `c_rd_op` is low. The two loads may come in either order. The bus sees `m_we`=1 with the loaded address and data.
- R4: An address load with `c_rd_op` low and no data loaded leaves the unit waiting, with `m_req` and `c_stall` low, until the data write arrives.
- R5: `c_stall` is high in every BUSY cycle and stays high until `m_done` or `m_abort`. The edge that samples either one moves to DONE. `c_ready` is then high for exactly that one cycle, with `c_stall` low.
- R6: On a completed read, `c_rdata` holds the bus read data by the ready cycle.
- R7: A master abort on a read loads the data register with zero.
- R8: A master abort on a write still completes with a ready pulse and leaves the data register unchanged.
- R9: A software write to the data register (`sw_sel`=1) has no effect, while a software read returns the register's current value.
- R10: A software write to the address register (`sw_sel`=0) updates the stored address (visible on `sw_rdata`) but starts no bus access.
- R11: Cache register writes during BUSY or DONE are ignored. The data-loaded flag is cleared on completion, so a later write access needs a fresh data load.
- R12: While `m_req` is high and neither `m_done` nor `m_abort` is seen, `m_req`, `m_we`, `m_addr` and `m_wdata` hold steady into the next cycle.
- R13: When `m_done` and `m_abort` arrive together on a read, the abort wins and the data register becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_addr_we | input | 1 | Cache writes the address register |
| c_addr_wdata | input | ADDR_W | Word address from the cache |
| c_data_we | input | 1 | Cache writes the data register |
| c_data_wdata | input | DATA_W | Write data from the cache |
| c_rd_op | input | 1 | High selects a read access |
| c_stall | output | 1 | Processor stall while the bus access is pending |
| c_ready | output | 1 | One-cycle completion pulse |
| c_rdata | output | DATA_W | Data register readback |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 1 | Software write target: 0 address, 1 data |
| sw_wdata | input | DATA_W | Software write value |
| sw_rsel | input | 1 | Software read select: 0 address, 1 data |
| sw_rdata | output | DATA_W | Software read value |
| m_req | output | 1 | Bus-master request |
| m_we | output | 1 | Bus access is a write |
| m_addr | output | ADDR_W | Bus word address |
| m_wdata | output | DATA_W | Bus write data |
| m_rdata | input | DATA_W | Bus read data, valid with `m_done` |
| m_done | input | 1 | Bus access finished |
| m_abort | input | 1 | Bus master abort |

## Verification
The assertions assume that the bus only pulses `m_done` or `m_abort` while `m_req` is high, and that each pulse lasts one cycle. They also assume that `m_rdata` is meaningful only alongside `m_done`. The bench's bus responder waits until it sees `m_req` before it drives a single-cycle done or abort. It drops both lines on the next cycle. The software-write checks depend on the cache not writing the data register in the same cycle, so the bench never overlaps the two.

// File: rtl/cbb_pkg.sv
package cbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ADDR_LOADED = 2'd1,
        ST_BUSY        = 2'd2,
        ST_DONE        = 2'd3
    } cbb_state_e;

    localparam logic SEL_ADDR = 1'b0;
    localparam logic SEL_DATA = 1'b1;

endpackage

// File: rtl/cbb_ctrl.sv
module cbb_ctrl
    import cbb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic c_addr_we,
    input  logic c_rd_op,
    input  logic data_ld,
    input  logic bus_end,
    output logic load_open,
    output logic busy,
    output logic op_wr,
    output logic finish,
    output logic c_stall,
    output logic c_ready
);

    cbb_state_e state_q;
    cbb_state_e state_d;
    logic       launch;

    // launch decision: read line has priority over a loaded data word
    always_comb begin
        launch = (state_q == ST_ADDR_LOADED) && (c_rd_op || data_ld);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (c_addr_we) begin
                    state_d = ST_ADDR_LOADED;
                end
            end
            ST_ADDR_LOADED: begin
                if (launch) begin
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (bus_end) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_wr   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                op_wr <= !c_rd_op;
            end
        end
    end

    always_comb begin
        load_open = 1'b0;
        busy      = 1'b0;
        finish    = 1'b0;
        c_stall   = 1'b0;
        c_ready   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_open = 1'b1;
            end
            ST_ADDR_LOADED: begin
                load_open = 1'b1;
            end
            ST_BUSY: begin
                busy    = 1'b1;
                c_stall = 1'b1;
                finish  = bus_end;
            end
            ST_DONE: begin
                c_ready = 1'b1;
            end
            default: begin
                load_open = 1'b0;
            end
        endcase
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        c_ready |=> !c_ready); // R5

    AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        c_ready |-> $past(bus_end)); // R5

    AST_STALL_TILL_END: assert property (@(posedge clk) disable iff (!rst_n)
        (c_stall && !bus_end) |=> c_stall); // R5

endmodule

// File: rtl/cbb_regs.sv
module cbb_regs
    import cbb_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_open,
    input  logic              c_addr_we,
    input  logic [ADDR_W-1:0] c_addr_wdata,
    input  logic              c_data_we,
    input  logic [DATA_W-1:0] c_data_wdata,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              sw_rsel,
    input  logic              capture,
    input  logic              capture_zero,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              finish,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              data_ld,
    output logic [DATA_W-1:0] sw_rdata
);

    logic cache_addr_wr;
    logic cache_data_wr;
    logic soft_addr_wr;

    always_comb begin
        cache_addr_wr = load_open && c_addr_we;
        cache_data_wr = load_open && c_data_we;
        soft_addr_wr  = load_open && sw_we && (sw_sel == SEL_ADDR) && !c_addr_we;
    end

    // address register: cache load first, software load second
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cache_addr_wr) begin
            addr_q <= c_addr_wdata;
        end else if (soft_addr_wr) begin
            addr_q <= sw_wdata[ADDR_W-1:0];
        end
    end

    // data register: bus capture or cache load; software writes never land
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= capture_zero ? '0 : bus_rdata;
        end else if (cache_data_wr) begin
            data_q <= c_data_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_ld <= 1'b0;
        end else if (finish) begin
            data_ld <= 1'b0;
        end else if (cache_data_wr) begin
            data_ld <= 1'b1;
        end
    end

    always_comb begin
        sw_rdata = (sw_rsel == SEL_DATA) ? data_q : DATA_W'(addr_q);
    end

    AST_SW_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_sel == SEL_DATA && !c_data_we && !capture) |=> $stable(data_q)); // R9

endmodule

// File: rtl/cbb_master.sv
module cbb_master #(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              op_wr,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    input  logic              m_done,
    input  logic              m_abort,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic              bus_end,
    output logic              capture,
    output logic              capture_zero
);

    always_comb begin
        m_req        = busy;
        m_we         = busy && op_wr;
        m_addr       = addr_q;
        m_wdata      = data_q;
        bus_end      = busy && (m_done || m_abort);
        capture      = bus_end && !op_wr;
        capture_zero = m_abort;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_done && !m_abort) |=>
            (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata))); // R12

endmodule

// File: rtl/cache_bus_bridge.sv
module cache_bus_bridge #(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_addr_we,
    input  logic [ADDR_W-1:0] c_addr_wdata,
    input  logic              c_data_we,
    input  logic [DATA_W-1:0] c_data_wdata,
    input  logic              c_rd_op,
    output logic              c_stall,
    output logic              c_ready,
    output logic [DATA_W-1:0] c_rdata,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              sw_rsel,
    output logic [DATA_W-1:0] sw_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_done,
    input  logic              m_abort
);

    logic              load_open;
    logic              busy;
    logic              op_wr;
    logic              finish;
    logic              bus_end;
    logic              capture;
    logic              capture_zero;
    logic              data_ld;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    cbb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_addr_we (c_addr_we),
        .c_rd_op   (c_rd_op),
        .data_ld   (data_ld),
        .bus_end   (bus_end),
        .load_open (load_open),
        .busy      (busy),
        .op_wr     (op_wr),
        .finish    (finish),
        .c_stall   (c_stall),
        .c_ready   (c_ready)
    );

    cbb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_open    (load_open),
        .c_addr_we    (c_addr_we),
        .c_addr_wdata (c_addr_wdata),
        .c_data_we    (c_data_we),
        .c_data_wdata (c_data_wdata),
        .sw_we        (sw_we),
        .sw_sel       (sw_sel),
        .sw_wdata     (sw_wdata),
        .sw_rsel      (sw_rsel),
        .capture      (capture),
        .capture_zero (capture_zero),
        .bus_rdata    (m_rdata),
        .finish       (finish),
        .addr_q       (addr_q),
        .data_q       (data_q),
        .data_ld      (data_ld),
        .sw_rdata     (sw_rdata)
    );

    cbb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .op_wr        (op_wr),
        .addr_q       (addr_q),
        .data_q       (data_q),
        .m_done       (m_done),
        .m_abort      (m_abort),
        .m_req        (m_req),
        .m_we         (m_we),
        .m_addr       (m_addr),
        .m_wdata      (m_wdata),
        .bus_end      (bus_end),
        .capture      (capture),
        .capture_zero (capture_zero)
    );

    assign c_rdata = data_q;

    AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_we && m_abort) |=> (c_rdata == '0)); // R7

    AST_READ_NOT_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(m_req) && $past(c_rd_op)) |-> !m_we); // R2

endmodule

// File: tb/sim_cache_bus_bridge.sv
module sim_cache_bus_bridge;

    localparam int AW = 30;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          c_addr_we = 1'b0;
    logic [AW-1:0] c_addr_wdata = '0;
    logic          c_data_we = 1'b0;
    logic [DW-1:0] c_data_wdata = '0;
    logic          c_rd_op = 1'b0;
    logic          c_stall;
    logic          c_ready;
    logic [DW-1:0] c_rdata;
    logic          sw_we = 1'b0;
    logic          sw_sel = 1'b0;
    logic [DW-1:0] sw_wdata = '0;
    logic          sw_rsel = 1'b0;
    logic [DW-1:0] sw_rdata;
    logic          m_req;
    logic          m_we;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic [DW-1:0] m_rdata = '0;
    logic          m_done = 1'b0;
    logic          m_abort = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cache_bus_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .c_addr_we(c_addr_we), .c_addr_wdata(c_addr_wdata),
        .c_data_we(c_data_we), .c_data_wdata(c_data_wdata),
        .c_rd_op(c_rd_op), .c_stall(c_stall), .c_ready(c_ready), .c_rdata(c_rdata),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .sw_rsel(sw_rsel), .sw_rdata(sw_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_done(m_done), .m_abort(m_abort)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cache_addr(input logic [AW-1:0] a);
        c_addr_we = 1'b1; c_addr_wdata = a;
        step();
        c_addr_we = 1'b0;
    endtask

    task automatic cache_data(input logic [DW-1:0] d);
        c_data_we = 1'b1; c_data_wdata = d;
        step();
        c_data_we = 1'b0;
    endtask

    // wait for a request, check it, answer after lat cycles, check completion
    task automatic serve(input string tag, input logic exp_we, input logic [AW-1:0] exp_a,
                         input logic [DW-1:0] exp_wd, input int lat, input logic [DW-1:0] rd,
                         input logic dn, input logic ab, input logic [DW-1:0] exp_rdata);
        int guard = 0;
        while (!m_req && guard < 20) begin
            step();
            guard++;
        end
        check({tag, " R2/R3 request seen"}, DW'(m_req), 1);
        check({tag, " R2/R3 m_we"}, DW'(m_we), DW'(exp_we));
        check({tag, " R2/R3 m_addr"}, DW'(m_addr), DW'(exp_a));
        if (exp_we) check({tag, " R3 m_wdata"}, m_wdata, exp_wd);
        for (int i = 0; i < lat; i++) begin
            check({tag, " R5 stall while busy"}, DW'(c_stall), 1);
            check({tag, " R12 addr held"}, DW'(m_addr), DW'(exp_a));
            step();
        end
        m_done = dn; m_abort = ab; m_rdata = rd;
        step();
        m_done = 1'b0; m_abort = 1'b0; m_rdata = '0;
        check({tag, " R5 ready pulse"}, DW'(c_ready), 1);
        check({tag, " R5 stall released"}, DW'(c_stall), 0);
        check({tag, " R6/R7/R8 data register"}, c_rdata, exp_rdata);
        step();
        check({tag, " R5 ready one cycle"}, DW'(c_ready), 0);
    endtask

    task automatic t_reset();
        check("R1 stall", DW'(c_stall), 0);
        check("R1 ready", DW'(c_ready), 0);
        check("R1 req", DW'(m_req), 0);
        sw_rsel = 1'b0; #1;
        check("R1 addr reg", sw_rdata, 0);
        sw_rsel = 1'b1; #1;
        check("R1 data reg", sw_rdata, 0);
    endtask

    task automatic t_read();
        c_rd_op = 1'b1;
        cache_addr(30'h0ABC_1234);
        check("R2 no req one edge after", DW'(m_req), 0);
        step();
        check("R2 req two edges after", DW'(m_req), 1);
        serve("read", 1'b0, 30'h0ABC_1234, '0, 3, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'hDEAD_BEEF);
        serve_idle("R2 idle after read");
    endtask

    task automatic serve_idle(input string tag);
        check({tag, " req low"}, DW'(m_req), 0);
        check({tag, " stall low"}, DW'(c_stall), 0);
    endtask

    task automatic t_write_addr_first();
        c_rd_op = 1'b0;
        cache_addr(30'h0000_0111);
        for (int i = 0; i < 3; i++) begin
            check("R4 waiting no req", DW'(m_req), 0);
            check("R4 waiting no stall", DW'(c_stall), 0);
            step();
        end
        cache_data(32'h1234_5678);
        serve("write-af", 1'b1, 30'h0000_0111, 32'h1234_5678, 1, '0, 1'b1, 1'b0, 32'h1234_5678);
    endtask

    task automatic t_write_data_first();
        c_rd_op = 1'b0;
        cache_data(32'hCAFE_0001);
        step();
        check("R3 data alone no req", DW'(m_req), 0);
        cache_addr(30'h2000_0002);
        serve("write-df", 1'b1, 30'h2000_0002, 32'hCAFE_0001, 0, '0, 1'b1, 1'b0, 32'hCAFE_0001);
    endtask

    task automatic t_read_abort();
        c_rd_op = 1'b1;
        cache_addr(30'h3FFF_FFF0);
        serve("read-abort R7", 1'b0, 30'h3FFF_FFF0, '0, 2, 32'h5555_AAAA, 1'b0, 1'b1, 32'h0);
    endtask

    task automatic t_write_abort();
        c_rd_op = 1'b0;
        cache_data(32'h0BAD_F00D);
        cache_addr(30'h0000_0040);
        serve("write-abort R8", 1'b1, 30'h0000_0040, 32'h0BAD_F00D, 1, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0BAD_F00D);
    endtask

    task automatic t_done_and_abort();
        c_rd_op = 1'b1;
        cache_addr(30'h0000_0077);
        serve("both R13", 1'b0, 30'h0000_0077, '0, 0, 32'h7777_7777, 1'b1, 1'b1, 32'h0);
    endtask

    task automatic t_sw_access();
        sw_we = 1'b1; sw_sel = 1'b1; sw_wdata = 32'hFEED_FACE;
        step();
        sw_we = 1'b0;
        sw_rsel = 1'b1; #1;
        check("R9 sw data write ignored", sw_rdata, 32'h0);
        check("R9 cache readback unchanged", c_rdata, 32'h0);
        c_rd_op = 1'b0;
        sw_we = 1'b1; sw_sel = 1'b0; sw_wdata = 32'h0000_0ABC;
        step();
        sw_we = 1'b0;
        sw_rsel = 1'b0; #1;
        check("R10 sw addr write visible", sw_rdata, 32'h0000_0ABC);
        step(); step();
        check("R10 sw addr write no req", DW'(m_req), 0);
        check("R10 sw addr write no stall", DW'(c_stall), 0);
    endtask

    task automatic t_busy_ignore();
        int guard = 0;
        c_rd_op = 1'b1;
        cache_addr(30'h0000_0500);
        while (!m_req && guard < 20) begin
            step();
            guard++;
        end
        c_addr_we = 1'b1; c_addr_wdata = 30'h0000_0999;
        c_data_we = 1'b1; c_data_wdata = 32'h9999_9999;
        step();
        c_addr_we = 1'b0; c_data_we = 1'b0;
        check("R11 addr write in BUSY ignored", DW'(m_addr), 32'h0000_0500);
        serve("busy-ignore R11", 1'b0, 30'h0000_0500, '0, 1, 32'h1111_2222, 1'b1, 1'b0, 32'h1111_2222);
        c_rd_op = 1'b0;
        cache_addr(30'h0000_0600);
        for (int i = 0; i < 3; i++) begin
            check("R11 data flag cleared no req", DW'(m_req), 0);
            step();
        end
        cache_data(32'h0000_ABCD);
        serve("after-clear R11", 1'b1, 30'h0000_0600, 32'h0000_ABCD, 0, '0, 1'b1, 1'b0, 32'h0000_ABCD);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_sw_access();
        t_read();
        t_write_addr_first();
        t_write_data_first();
        t_read_abort();
        t_write_abort();
        t_done_and_abort();
        t_busy_ignore();
        repeat (3) step();
        finish_run();
    end

endmodule